// File: doc/BRIEF.md
# Phase Voltage Routing Crossbar

The crossbar takes three phase voltage sample streams (VA, VB and VC) and places each one into one of three computational datapaths (A, B and C). Downstream logic can then compute power for a phase from the voltage of a different phase. A 2-bit routing code for each source, held in a configuration register, selects that source's destination. The code meanings rotate from one source to the next. Code 00 always keeps a source on its own path.

All three sources share one sample strobe. Each strobed sample set is routed in a single cycle from the configuration that is current at that strobe, so a set is never split across two configurations. When two sources aim at the same path, a fixed priority settles it. A path that no source reaches reports no valid data.

Top module: `phase_route_xbar`

## Requirements
- R1: After reset all path outputs are zero with valid low, and all routing codes are 00, so the first sample set routes VA to path A, VB to path B and VC to path C.
- R2: The VA code is configuration bits [9:8]. 00 routes VA to path A, 01 to path B, 10 to path C.
- R3: The VB code is configuration bits [11:10]. 00 routes VB to path B, 01 to path C, 10 to path A.
- R4: The VC code is configuration bits [13:12]. 00 routes VC to path C, 01 to path A, 10 to path B.
- R5: A code of 11 in any field routes exactly as 00.
- R6: When several sources target one path, the path carries the lowest-lettered of them (VA over VB over VC).
- R7: A path that no source targets outputs zero with its valid low.
- R8: A sample set strobed on smp_valid_i appears on the path outputs one clock later, with path_vld_o set on exactly the targeted paths. Path index 0 is A, 1 is B and 2 is C.
- R9: A configuration write is applied from the next strobed sample set on. A set strobed in the same cycle as the write uses the old codes. Configuration bits outside [13:8] have no effect.
- R10: In the cycle after a cycle with smp_valid_i low, every path_vld_o bit is low and every path output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | CFG_W (16) | Configuration write data; routing codes in [13:8] |
| smp_valid_i | input | 1 | Sample set strobe for all three sources |
| va_i | input | DW (24) | Phase A voltage sample |
| vb_i | input | DW (24) | Phase B voltage sample |
| vc_i | input | DW (24) | Phase C voltage sample |
| path_data_o | output | 3 x DW | Routed sample per datapath, index 0=A, 1=B, 2=C |
| path_vld_o | output | 3 | Valid strobe per datapath |

## Verification
The assertions check on every cycle that an invalid path carries zero, that an idle cycle produces no valid output, that a strobe always yields at least one valid path, that the routing state changes only on a write, and that identity codes, reserved codes and the VA-to-B code route as required. Some behaviours can only be shown by the bench's scenarios. These are the rotated meaning of each code for VB and VC, the priority among colliding sources, the empty paths left by a collision, a write landing in the same cycle as a strobe, and junk in the unused configuration bits. The bench checks each of these against its own routing model.

// File: rtl/phase_route_pkg.sv
package phase_route_pkg;
  localparam int NPH = 3;
  typedef logic [1:0] phase_t;
  localparam phase_t PH_A = 2'd0;
  localparam phase_t PH_B = 2'd1;
  localparam phase_t PH_C = 2'd2;
endpackage

// File: rtl/phase_route_cfg.sv
module phase_route_cfg #(
  parameter int RW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] wdata_i,
  output logic [RW-1:0] rt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rt_o <= '0;
    else if (we_i) rt_o <= wdata_i;
  end
endmodule

// File: rtl/phase_route_decode.sv
module phase_route_decode
  import phase_route_pkg::*;
#(
  parameter int RW = 2 * NPH
) (
  input  logic   [RW-1:0]     rt_i,
  output phase_t [NPH-1:0]    dest_o
);
  for (genvar s = 0; s < NPH; s++) begin : g_src
    localparam logic [2:0] SID = 3'(s);
    logic [1:0] code;
    logic [2:0] off, sum;
    assign code = rt_i[2*s +: 2];
    // 01 -> next path, 10 -> the one after, 00/11 -> own path
    always_comb begin
      unique case (code)
        2'b01:   off = 3'd1;
        2'b10:   off = 3'd2;
        default: off = 3'd0;
      endcase
      sum = SID + off;
      if (sum >= 3'(NPH)) sum = sum - 3'(NPH);
      dest_o[s] = sum[1:0];
    end
  end
endmodule

// File: rtl/phase_route_mux.sv
module phase_route_mux
  import phase_route_pkg::*;
#(
  parameter int DW   = 24,
  parameter int PATH = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  phase_t [NPH-1:0]         dest_i,
  input  logic   [NPH-1:0][DW-1:0] smp_i,
  output logic   [DW-1:0]          data_o,
  output logic                     vld_o
);
  localparam phase_t PID = phase_t'(PATH);

  logic         hit;
  logic [1:0]   sel;

  // descending scan: lowest source index assigned last, so it wins
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int s = NPH - 1; s >= 0; s--) begin
      if (dest_i[s] == PID) begin
        hit = 1'b1;
        sel = 2'(s);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o  <= valid_i & hit;
      data_o <= (valid_i & hit) ? smp_i[sel] : '0;
    end
  end
endmodule

// File: rtl/phase_route_xbar.sv
module phase_route_xbar
  import phase_route_pkg::*;
#(
  parameter int DW        = 24,
  parameter int CFG_W     = 16,
  parameter int FIELD_LSB = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [CFG_W-1:0]         cfg_wdata_i,
  input  logic                     smp_valid_i,
  input  logic [DW-1:0]            va_i,
  input  logic [DW-1:0]            vb_i,
  input  logic [DW-1:0]            vc_i,
  output logic [NPH-1:0][DW-1:0]   path_data_o,
  output logic [NPH-1:0]           path_vld_o
);
  localparam int RW = 2 * NPH;

  logic   [RW-1:0]          rt_q;
  phase_t [NPH-1:0]         dest;
  logic   [NPH-1:0][DW-1:0] smp;

  assign smp = {vc_i, vb_i, va_i};

  // single register: a strobed set always sees one consistent code set
  phase_route_cfg #(.RW(RW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i[FIELD_LSB +: RW]),
    .rt_o    (rt_q)
  );

  phase_route_decode #(.RW(RW)) u_dec (
    .rt_i   (rt_q),
    .dest_o (dest)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_path
    phase_route_mux #(.DW(DW), .PATH(p)) u_mux (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (smp_valid_i),
      .dest_i  (dest),
      .smp_i   (smp),
      .data_o  (path_data_o[p]),
      .vld_o   (path_vld_o[p])
    );
  end
endmodule

// File: rtl/phase_route_xbar_chk.sv
module phase_route_xbar_chk #(
  parameter int DW = 24,
  parameter int RW = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_we_i,
  input logic                smp_valid_i,
  input logic [DW-1:0]       va_i,
  input logic [DW-1:0]       vb_i,
  input logic [DW-1:0]       vc_i,
  input logic [2:0][DW-1:0]  path_data_o,
  input logic [2:0]          path_vld_o,
  input logic [RW-1:0]       rt_q
);
  p_identity_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && rt_q == '0) |=> (path_vld_o == 3'b111 &&
      path_data_o[0] == $past(va_i) && path_data_o[1] == $past(vb_i) &&
      path_data_o[2] == $past(vc_i)));

  p_va_to_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && rt_q[1:0] == 2'b01) |=> (path_vld_o[1] && path_data_o[1] == $past(va_i)));

  p_reserved_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && rt_q == {RW{1'b1}}) |=> (path_vld_o == 3'b111 &&
      path_data_o[0] == $past(va_i) && path_data_o[1] == $past(vb_i) &&
      path_data_o[2] == $past(vc_i)));

  p_zero_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !path_vld_o[0] |-> path_data_o[0] == '0);
  p_zero_b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !path_vld_o[1] |-> path_data_o[1] == '0);
  p_zero_c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !path_vld_o[2] |-> path_data_o[2] == '0);

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> path_vld_o != 3'b000);

  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(rt_q));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> (path_vld_o == 3'b000 && path_data_o == '0));
endmodule

bind phase_route_xbar phase_route_xbar_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .smp_valid_i (smp_valid_i),
  .va_i        (va_i),
  .vb_i        (vb_i),
  .vc_i        (vc_i),
  .path_data_o (path_data_o),
  .path_vld_o  (path_vld_o),
  .rt_q        (rt_q)
);

// File: tb/phase_route_xbar_test.sv
`timescale 1ns/1ps
module phase_route_xbar_test;
  localparam int DW = 24;
  localparam int CFG_W = 16;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  cfg_we_i = 1'b0;
  logic [CFG_W-1:0]      cfg_wdata_i = '0;
  logic                  smp_valid_i = 1'b0;
  logic [DW-1:0]         va_i = '0, vb_i = '0, vc_i = '0;
  logic [2:0][DW-1:0]    path_data_o;
  logic [2:0]            path_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [CFG_W-1:0] cur_cfg = '0;

  always #2.5 clk_i = ~clk_i;

  phase_route_xbar #(.DW(DW), .CFG_W(CFG_W), .FIELD_LSB(8)) uut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .smp_valid_i,
    .va_i, .vb_i, .vc_i, .path_data_o, .path_vld_o
  );

  function automatic int dest_of(int src, logic [1:0] code);
    case (code)
      2'b01:   return (src + 1) % 3;
      2'b10:   return (src + 2) % 3;
      default: return src;
    endcase
  endfunction

  task automatic check(string tag, logic [2:0] ev, logic [2:0][DW-1:0] ed);
    for (int p = 0; p < 3; p++) begin
      n_chk++;
      if (path_vld_o[p] !== ev[p] || path_data_o[p] !== ed[p]) begin
        n_bad++;
        $display("FAIL %s path %0d: vld=%b data=%h expected vld=%b data=%h",
                 tag, p, path_vld_o[p], path_data_o[p], ev[p], ed[p]);
      end
    end
  endtask

  // expected outputs for one strobed set under configuration c
  task automatic expect_set(string tag, logic [CFG_W-1:0] c,
                            logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] cc);
    logic [2:0] ev;
    logic [2:0][DW-1:0] ed;
    logic [2:0][DW-1:0] src;
    src = {cc, b, a};
    ev = '0;
    ed = '0;
    for (int s = 2; s >= 0; s--) begin
      int d;
      d = dest_of(s, c[8 + 2*s +: 2]);
      ev[d] = 1'b1;
      ed[d] = src[s];
    end
    check(tag, ev, ed);
  endtask

  task automatic write_cfg(logic [CFG_W-1:0] c);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_wdata_i = c;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    cur_cfg = c;
  endtask

  task automatic send(string tag, logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
    @(negedge clk_i);
    smp_valid_i = 1'b1;
    va_i = a; vb_i = b; vc_i = c;
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    expect_set(tag, cur_cfg, a, b, c);
  endtask

  initial begin
    logic [CFG_W-1:0] old_cfg;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 reset", 3'b000, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", 3'b000, '0);
    send("R1 identity", 24'h111111, 24'h222222, 24'h333333);
    // R10 idle
    @(negedge clk_i);
    check("R10 idle", 3'b000, '0);
    // R2/R3/R4 all codes 01 and all codes 10
    write_cfg(16'h1500);
    send("R2/R3/R4 rotate01", 24'hA00001, 24'hB00002, 24'hC00003);
    write_cfg(16'h2A00);
    send("R2/R3/R4 rotate10", 24'hA00011, 24'hB00012, 24'hC00013);
    // R5 reserved codes
    write_cfg(16'h3F00);
    send("R5 reserved", 24'h0A0A0A, 24'h0B0B0B, 24'h0C0C0C);
    // R6/R7 all three aim at path A
    write_cfg(16'h1800);
    check_collide_a();
    // R6/R7 VB and VC aim at path B, VA at C
    write_cfg(16'h2200);
    send("R6/R7 collide B", 24'h000AAA, 24'h000BBB, 24'h000CCC);
    // R9 junk bits only
    write_cfg(16'hC0FF);
    send("R9 junk bits", 24'h123456, 24'h654321, 24'hABCDEF);
    // R9 write in same cycle as a strobe
    old_cfg = cur_cfg;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = 16'h1500;
    smp_valid_i = 1'b1; va_i = 24'h5A5A5A; vb_i = 24'h6B6B6B; vc_i = 24'h7C7C7C;
    @(negedge clk_i);
    cfg_we_i = 1'b0; smp_valid_i = 1'b0;
    expect_set("R9 same-cycle old", old_cfg, 24'h5A5A5A, 24'h6B6B6B, 24'h7C7C7C);
    cur_cfg = 16'h1500;
    send("R9 next set new", 24'h5A5A5B, 24'h6B6B6C, 24'h7C7C7D);
    // random mix, R8 latency and R2..R7 under random codes
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 3 == 0) write_cfg(16'($urandom));
      if ($urandom % 4 == 0) begin
        @(negedge clk_i);
        check("R10 random idle", 3'b000, '0);
      end
      send("R8 random", 24'($urandom), 24'($urandom), 24'($urandom));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic check_collide_a();
    logic [2:0][DW-1:0] ed;
    @(negedge clk_i);
    smp_valid_i = 1'b1;
    va_i = 24'hAAAAAA; vb_i = 24'hBBBBBB; vc_i = 24'hCCCCCC;
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    ed = '0;
    ed[0] = 24'hAAAAAA;
    check("R6/R7 collide A", 3'b001, ed);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule